// File: doc/BRIEF.md
# Circular Buffer Space Allocator

This block shares one circular RAM of 32-bit words between a producer that stores application payloads and a consumer that processes them later. A producer first asks for room by raising a request with a byte count. One cycle later the allocator either acknowledges and returns the word address where the payload will start, or keeps the acknowledge low to say the room is not there. An acknowledged producer must start its burst (marked by start and end flags) in the very cycle it lowers the request. The allocator then steers each valid word onto the RAM write port at consecutive word addresses, wrapping past the last word back to zero.

A cancel input aborts a reservation or a burst in progress and returns the write pointer to where that reservation began. Space is given back when the consumer reports the byte size of a finished command; the read pointer then moves forward by that many words. Byte counts are rounded up to whole words on both sides. One word of the ring is always kept empty, so equal pointers mean an empty ring.

Top module: `ring_space_alloc`

## Requirements
- R1: While reset is held and after it is released, the acknowledge and the RAM write strobe are low and the returned start pointer is 0.
- R2: A request seen while idle whose word count fits is acknowledged by a one-cycle high on the acknowledge in the next cycle.
- R3: With the acknowledge, the start pointer output carries the current write word address, zero-extended to 16 bits.
- R4: A request whose word count (bytes divided by 4, rounded up) exceeds the free words, computed as ring depth minus one minus the words in use, gets no acknowledge and reserves nothing; the request must drop before a new one is looked at.
- R5: After an acknowledge, a start flag in the cycle the request drops opens the burst; every word presented with its valid flag is written one cycle later at the next consecutive address, and a valid word carrying the end flag closes the burst (start and end may share one word).
- R6: Valid words beyond the reserved word count are discarded and do not advance the write pointer.
- R7: A cancel after the acknowledge returns the write pointer to the start pointer of that reservation, so the next request gets the same start pointer.
- R8: If no start flag and no cancel is present in the cycle the request drops, the reservation is abandoned, nothing is written, and a start flag arriving later has no effect.
- R9: A completion strobe advances the read pointer by its byte size rounded up to whole words, which raises the free space by that amount.
- R10: The write address wraps from the last word of the ring (4095 with defaults) to word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Space request |
| req_bytes_i | input | 16 | Requested size in bytes |
| ack_o | output | 1 | Request granted (one-cycle pulse) |
| start_ptr_o | output | 16 | Word address where the granted payload starts |
| sof_i | input | 1 | First word of burst |
| eof_i | input | 1 | Last word of burst |
| wvalid_i | input | 1 | Data word valid |
| wdata_i | input | 32 | Data word |
| cancel_i | input | 1 | Abort current reservation or burst |
| done_valid_i | input | 1 | Completed-command strobe |
| done_bytes_i | input | 16 | Byte size of completed command |
| mem_we_o | output | 1 | RAM write strobe |
| mem_waddr_o | output | 12 | RAM word address |
| mem_wdata_o | output | 32 | RAM write data |

## Verification
The hardest states to reach from the ports are the exact full-ring boundary and the wrap of the write address, because the pointers can only be moved by real bursts and completion strobes. The bench first parks the write pointer a few words in, probes the free space one byte either side of the exact fit, then releases space with completion sizes that are not multiples of four so the rounding shows up as a moved boundary. It then streams a burst of 4092 words that ends precisely on the last ring word, so the next grant must return address 0.

// File: rtl/ralloc_pkg.sv
package ralloc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_BLOCK = 2'd2,
    ST_DATA  = 2'd3
  } wstate_e;
endpackage

// File: rtl/ralloc_words.sv
// Byte count to whole 32-bit word count, rounded up.
module ralloc_words #(
  parameter int SIZE_W = 16
) (
  input  logic [SIZE_W-1:0] bytes_i,
  output logic [SIZE_W-1:0] words_o
);
  always_comb begin
    words_o = {2'b00, bytes_i[SIZE_W-1:2]} + SIZE_W'(|bytes_i[1:0]);
  end
endmodule

// File: rtl/ralloc_space.sv
// Free-word calculation and fit decision.
module ralloc_space #(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16
) (
  input  logic [ADDR_W-1:0] wr_ptr_i,
  input  logic [ADDR_W-1:0] rd_ptr_i,
  input  logic [SIZE_W-1:0] need_words_i,
  output logic              fits_o
);
  logic [ADDR_W-1:0] used_words;
  logic [ADDR_W-1:0] free_words;

  always_comb begin
    used_words = wr_ptr_i - rd_ptr_i;
    free_words = {ADDR_W{1'b1}} - used_words;
    fits_o     = need_words_i <= {{(SIZE_W-ADDR_W){1'b0}}, free_words};
  end
endmodule

// File: rtl/ralloc_rdptr.sv
// Read pointer, advanced by completed sizes.
module ralloc_rdptr #(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_valid_i,
  input  logic [SIZE_W-1:0] done_words_i,
  output logic [ADDR_W-1:0] rd_ptr_o
);
  logic [ADDR_W-1:0] rd_q, rd_n;
  logic [SIZE_W-1:0] sum_ext;

  always_comb begin
    sum_ext = {{(SIZE_W-ADDR_W){1'b0}}, rd_q} + done_words_i;
    rd_n    = sum_ext[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rd_q <= '0;
    else if (done_valid_i) rd_q <= rd_n;
  end

  assign rd_ptr_o = rd_q;
endmodule

// File: rtl/ralloc_wrctl.sv
// Reservation handshake, burst sequencing and write pointer.
module ralloc_wrctl
  import ralloc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              fits_i,
  input  logic [SIZE_W-1:0] need_words_i,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              wvalid_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cancel_i,
  output logic [ADDR_W-1:0] wr_ptr_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] start_ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  wstate_e           st_q, st_n;
  logic [ADDR_W-1:0] wr_q, wr_n, base_q, base_n, sp_q, sp_n, wa_q, wa_n;
  logic [SIZE_W-1:0] rem_q, rem_n;
  logic              ack_q, ack_n, we_q, we_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic              take;

  always_comb begin
    st_n   = st_q;
    wr_n   = wr_q;
    base_n = base_q;
    sp_n   = sp_q;
    rem_n  = rem_q;
    ack_n  = 1'b0;
    we_n   = 1'b0;
    wa_n   = wa_q;
    wd_n   = wd_q;
    take   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          if (fits_i) begin
            ack_n  = 1'b1;
            sp_n   = wr_q;
            base_n = wr_q;
            rem_n  = need_words_i;
            st_n   = ST_HOLD;
          end else begin
            st_n = ST_BLOCK;
          end
        end
      end
      ST_BLOCK: if (!req_i) st_n = ST_IDLE;
      ST_HOLD: begin
        if (cancel_i) begin
          wr_n = base_q;
          st_n = ST_IDLE;
        end else if (!req_i) begin
          if (sof_i) begin
            st_n = ST_DATA;
            take = wvalid_i;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (cancel_i) begin
          wr_n = base_q;
          st_n = ST_IDLE;
        end else begin
          take = wvalid_i;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (take) begin
      if (rem_q != '0) begin
        we_n  = 1'b1;
        wa_n  = wr_q;
        wd_n  = wdata_i;
        wr_n  = wr_q + 1'b1;
        rem_n = rem_q - 1'b1;
      end
      if (eof_i) st_n = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wr_q   <= '0;
      base_q <= '0;
      sp_q   <= '0;
      rem_q  <= '0;
      ack_q  <= 1'b0;
      we_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      st_q   <= st_n;
      wr_q   <= wr_n;
      base_q <= base_n;
      sp_q   <= sp_n;
      rem_q  <= rem_n;
      ack_q  <= ack_n;
      we_q   <= we_n;
      wa_q   <= wa_n;
      wd_q   <= wd_n;
    end
  end

  assign wr_ptr_o    = wr_q;
  assign ack_o       = ack_q;
  assign start_ptr_o = sp_q;
  assign mem_we_o    = we_q;
  assign mem_waddr_o = wa_q;
  assign mem_wdata_o = wd_q;
endmodule

// File: rtl/ring_space_alloc.sv
module ring_space_alloc #(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16,
  parameter int PTR_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [SIZE_W-1:0] req_bytes_i,
  output logic              ack_o,
  output logic [PTR_W-1:0]  start_ptr_o,
  input  logic              sof_i,
  input  logic              eof_i,
  input  logic              wvalid_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              cancel_i,
  input  logic              done_valid_i,
  input  logic [SIZE_W-1:0] done_bytes_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int PAD_W = PTR_W - ADDR_W;

  logic [SIZE_W-1:0] need_words, done_words;
  logic [ADDR_W-1:0] wr_ptr, rd_ptr, start_word;
  logic              fits;

  ralloc_words #(.SIZE_W(SIZE_W)) u_req_words (
    .bytes_i(req_bytes_i), .words_o(need_words)
  );

  ralloc_words #(.SIZE_W(SIZE_W)) u_done_words (
    .bytes_i(done_bytes_i), .words_o(done_words)
  );

  ralloc_space #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_space (
    .wr_ptr_i(wr_ptr), .rd_ptr_i(rd_ptr),
    .need_words_i(need_words), .fits_o(fits)
  );

  ralloc_rdptr #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_rdptr (
    .clk(clk), .rst_n(rst_n), .done_valid_i(done_valid_i),
    .done_words_i(done_words), .rd_ptr_o(rd_ptr)
  );

  ralloc_wrctl #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) u_wrctl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .fits_i(fits),
    .need_words_i(need_words), .sof_i(sof_i), .eof_i(eof_i),
    .wvalid_i(wvalid_i), .wdata_i(wdata_i), .cancel_i(cancel_i),
    .wr_ptr_o(wr_ptr), .ack_o(ack_o), .start_ptr_o(start_word),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o)
  );

  assign start_ptr_o = {{PAD_W{1'b0}}, start_word};
endmodule

// File: rtl/ring_space_alloc_chk.sv
module ring_space_alloc_chk #(
  parameter int ADDR_W = 12,
  parameter int SIZE_W = 16,
  parameter int PTR_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [SIZE_W-1:0] req_bytes_i,
  input logic              ack_o,
  input logic [PTR_W-1:0]  start_ptr_o,
  input logic              wvalid_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_waddr_o
);
  localparam int MAXW = (1 << ADDR_W) - 1;

  logic [SIZE_W:0] req_need;
  logic            too_big;
  assign req_need = ({1'b0, req_bytes_i} + (SIZE_W+1)'(3)) >> 2;
  assign too_big  = req_need > (SIZE_W+1)'(MAXW);

  p_ack_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(req_i));

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  p_refuse_oversize_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_i && too_big) |-> !ack_o);

  p_ptr_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (start_ptr_o <= PTR_W'(MAXW)));

  p_write_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(wvalid_i));

  p_addr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_waddr_o == $past(mem_waddr_o) + 1'b1));
endmodule

bind ring_space_alloc ring_space_alloc_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_bytes_i(req_bytes_i),
  .ack_o(ack_o), .start_ptr_o(start_ptr_o), .wvalid_i(wvalid_i),
  .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o)
);

// File: tb/ring_space_alloc_bench.sv
module ring_space_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i = 1'b0;
  logic [15:0] req_bytes_i = '0;
  logic        ack_o;
  logic [15:0] start_ptr_o;
  logic        sof_i = 1'b0, eof_i = 1'b0, wvalid_i = 1'b0, cancel_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        done_valid_i = 1'b0;
  logic [15:0] done_bytes_i = '0;
  logic        mem_we_o;
  logic [11:0] mem_waddr_o;
  logic [31:0] mem_wdata_o;

  int checks = 0;
  int failures = 0;
  int writes = 0;
  logic [31:0] ram [4096];

  always #5 clk = ~clk;

  ring_space_alloc u_ring_space_alloc (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_bytes_i(req_bytes_i),
    .ack_o(ack_o), .start_ptr_o(start_ptr_o), .sof_i(sof_i), .eof_i(eof_i),
    .wvalid_i(wvalid_i), .wdata_i(wdata_i), .cancel_i(cancel_i),
    .done_valid_i(done_valid_i), .done_bytes_i(done_bytes_i),
    .mem_we_o(mem_we_o), .mem_waddr_o(mem_waddr_o), .mem_wdata_o(mem_wdata_o)
  );

  always @(negedge clk) begin
    if (mem_we_o) begin
      ram[mem_waddr_o] = mem_wdata_o;
      writes = writes + 1;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_i = 0; sof_i = 0; eof_i = 0; wvalid_i = 0; cancel_i = 0; done_valid_i = 0;
    end
  endtask

  // Raise a request for one cycle, return ack and pointer seen the next cycle.
  task automatic request(input logic [15:0] b, output logic a, output logic [15:0] p);
    @(negedge clk);
    req_i = 1; req_bytes_i = b;
    @(negedge clk);
    a = ack_o; p = start_ptr_o;
  endtask

  // Called right after request: drops req and streams n words.
  task automatic burst(input int n, input logic [31:0] base);
    req_i = 0;
    for (int i = 0; i < n; i++) begin
      sof_i = (i == 0); eof_i = (i == n - 1); wvalid_i = 1; wdata_i = base + 32'(i);
      @(negedge clk);
    end
    sof_i = 0; eof_i = 0; wvalid_i = 0;
  endtask

  task automatic release_bytes(input logic [15:0] b);
    @(negedge clk);
    done_valid_i = 1; done_bytes_i = b;
    @(negedge clk);
    done_valid_i = 0;
  endtask

  // Probe: expect ack a_exp; abandon the reservation afterwards.
  task automatic probe(input logic [15:0] b, input logic a_exp, input string tag);
    logic a; logic [15:0] p;
    request(b, a, p);
    check(a == a_exp, tag, a, a_exp);
    quiet(2);
  endtask

  task automatic t_reset;
    check(ack_o == 0, "R1 ack after reset", ack_o, 0);
    check(mem_we_o == 0, "R1 write strobe after reset", mem_we_o, 0);
    check(start_ptr_o == 0, "R1 start ptr after reset", start_ptr_o, 0);
  endtask

  task automatic t_basic;
    logic a; logic [15:0] p; int w0;
    w0 = writes;
    request(16'd10, a, p);
    check(a == 1, "R2 ack for 10 bytes", a, 1);
    check(p == 0, "R3 first start ptr", p, 0);
    burst(3, 32'hA000_0000);
    quiet(2);
    check(writes - w0 == 3, "R5 three words written", writes - w0, 3);
    for (int i = 0; i < 3; i++)
      check(ram[i] == 32'hA000_0000 + 32'(i), "R5 word content", ram[i], 32'hA000_0000 + 32'(i));
    check(ack_o == 0, "R2 ack is a pulse", ack_o, 0);
  endtask

  task automatic t_overflow;
    logic a; logic [15:0] p; int w0;
    w0 = writes;
    request(16'd4, a, p);
    check(a == 1 && p == 3, "R3 ptr after 3-word burst", p, 3);
    burst(3, 32'hB000_0000);
    quiet(2);
    check(writes - w0 == 1, "R6 extra words dropped", writes - w0, 1);
    check(ram[3] == 32'hB000_0000, "R6 kept first word", ram[3], 32'hB000_0000);
  endtask

  task automatic t_cancel;
    logic a; logic [15:0] p;
    request(16'd8, a, p);
    check(p == 4, "R6 write ptr not advanced by dropped words", p, 4);
    req_i = 0; sof_i = 1; wvalid_i = 1; wdata_i = 32'hC0;
    @(negedge clk);
    sof_i = 0; wvalid_i = 0; cancel_i = 1;
    quiet(2);
    request(16'd8, a, p);
    check(a == 1 && p == 4, "R7 cancel rolls ptr back", p, 4);
    quiet(2);
  endtask

  task automatic t_ignore;
    logic a; logic [15:0] p; int w0;
    w0 = writes;
    request(16'd8, a, p);
    req_i = 0;
    @(negedge clk);
    sof_i = 1; eof_i = 1; wvalid_i = 1; wdata_i = 32'hDEAD;
    quiet(3);
    check(writes == w0, "R8 late sof writes nothing", writes - w0, 0);
    request(16'd8, a, p);
    check(a == 1 && p == 4, "R8 ptr unchanged after ignored write", p, 4);
    quiet(2);
  endtask

  task automatic t_capacity;
    // wr=4, rd=0: 4091 free words
    probe(16'd16364, 1'b1, "R4 exact fit 4091 words");
    probe(16'd16365, 1'b0, "R4 one byte over refused");
    probe(16'd65535, 1'b0, "R4 huge request refused");
  endtask

  task automatic t_release;
    release_bytes(16'd3);   // 1 word, rd=1
    probe(16'd16368, 1'b1, "R9 3-byte release frees one word");
    probe(16'd16369, 1'b0, "R9 boundary after release");
    release_bytes(16'd12);  // rd=4
    probe(16'd16380, 1'b1, "R9 empty ring fits 4095 words");
    probe(16'd16381, 1'b0, "R4 4096 words never fit");
  endtask

  task automatic t_wrap;
    logic a; logic [15:0] p; int w0;
    w0 = writes;
    request(16'd16368, a, p);
    check(a == 1 && p == 4, "R2 large grant at 4", p, 4);
    burst(4092, 32'h1000_0000);
    quiet(2);
    check(writes - w0 == 4092, "R5 long burst count", writes - w0, 4092);
    check(ram[4095] == 32'h1000_0000 + 32'd4091, "R10 last ring word", ram[4095], 32'h1000_0000 + 32'd4091);
    release_bytes(16'd16368);
    w0 = writes;
    request(16'd8, a, p);
    check(a == 1 && p == 0, "R10 ptr wrapped to 0", p, 0);
    burst(2, 32'hE000_0000);
    quiet(2);
    check(ram[0] == 32'hE000_0000 && ram[1] == 32'hE000_0001, "R10 words at 0 and 1", ram[1], 32'hE000_0001);
  endtask

  task automatic t_single;
    logic a; logic [15:0] p;
    request(16'd4, a, p);
    check(p == 2, "R3 ptr after wrap burst", p, 2);
    burst(1, 32'h5555_AAAA);
    quiet(2);
    check(ram[2] == 32'h5555_AAAA, "R5 sof and eof on one word", ram[2], 32'h5555_AAAA);
    request(16'd4, a, p);
    check(p == 3, "R5 ptr after single word", p, 3);
    quiet(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures = failures + 1;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    quiet(2);
    t_reset();
    t_basic();
    t_overflow();
    t_cancel();
    t_ignore();
    t_capacity();
    t_release();
    t_wrap();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule